// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a system address bus and a group of eight external memory chip selects. Each select owns a small configuration word that places a window in the physical address space. The word holds a base, a size code and an enable. When an access strobe is present, the block compares the address against every enabled window. It then drives a one-hot select vector, the byte offset of the access inside the chosen window, and a miss flag when no window claims the address. Windows start on 16 MB boundaries. Their size is a power of two from 16 MB to 256 MB, set by a 4-bit mask code.

Software programs the windows through a simple register port. A write lands on the next clock edge. A read returns the stored word combinationally. When two enabled windows claim the same address, the lower-numbered select wins and an overlap flag is raised. The block does not arbitrate any further. It also reports, for each select, whether its stored mask code is one of the legal codes. The 256 MB code counts as legal only when the `ALLOW_FULL` parameter is set. The decode path is purely combinational.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, select 0 holds word 0xF40 (enabled, base 0, mask 0xF). Every other select holds 0xF00 (disabled, base 0, mask 0xF), and no mask is flagged.
- R2: The window word of select i is at register byte address 0x60 + 0x30*i + 0x18. A write there stores `regWdata & 0xF7F`, so bit 7 and bits 31:12 read back as zero. The new value is visible from the next rising clock edge. Writes to any other address change no stored word, and reads of any other address return zero.
- R3: Word fields are: base in bits [5:0], enable in bit 6, mask code in bits [11:8]. The window base is the base field shifted left by 24.
- R4: Let sizeM1 = 0x0FFFFFFF with (mask << 24) cleared. Select i claims an address A when `((A ^ (base << 24)) & ~sizeM1) == 0`. So mask 0xF gives 16 MB, 0xE gives 32 MB, 0xC gives 64 MB, 0x8 gives 128 MB and 0x0 gives 256 MB.
- R5: A select whose enable bit is clear never appears in `csSel`.
- R6: When several selects claim the address, `csSel` has only the lowest-numbered claimant set, and `overlap` is 1. `overlap` is 0 when at most one select claims the address.
- R7: `csOffset` equals `A & sizeM1` of the winning select, and is zero when nothing is selected.
- R8: With `accValid` high, `miss` is 1 exactly when `csSel` is zero. With `accValid` low, `csSel`, `csOffset`, `miss` and `overlap` are all zero.
- R9: `badMask[i]` is 1 when select i's mask code is not one of 0x8, 0xC, 0xE, 0xF. Code 0x0 also counts as legal when `ALLOW_FULL` is 1. The flag follows the stored word whether or not the select is enabled.
- R10: Decode outputs respond to `accAddr` and `accValid` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| accValid | input | 1 | Access strobe |
| accAddr | input | 32 | System physical address of the access |
| csSel | output | 8 | One-hot chip-select vector |
| csOffset | output | 32 | Byte offset inside the selected window |
| miss | output | 1 | Strobed access matched no enabled window |
| overlap | output | 1 | More than one enabled window matched |
| badMask | output | 8 | Per-select illegal mask code flag |

## Verification
A configuration write and a decode can fall in the same cycle. The decode must use the old window until the clock edge and the new one after it. The bench provokes this by moving a window while holding a strobed address that only the old placement covers. It samples `csSel` just before the edge and again just after it, and expects a hit first and a miss second. Between such events, every top address byte is swept under several window layouts. The layouts include overlapping, disabled and 256 MB windows. The select, offset, miss and overlap results are compared against an arithmetic model of R4 through R8.

// File: rtl/cs_win_pkg.sv
`timescale 1ns/1ps
package cs_win_pkg;

  // Layout of the stored window word
  localparam int CFG_W     = 12;
  localparam int BASE_W    = 6;
  localparam int VALID_BIT = 6;
  localparam int RSVD_BIT  = 7;
  localparam int MASK_LSB  = 8;
  localparam int MASK_W    = 4;

  localparam logic [CFG_W-1:0] CFG_KEEP    = 12'hF7F;
  localparam logic [CFG_W-1:0] CFG_RST_OFF = 12'hF00;
  localparam logic [CFG_W-1:0] CFG_RST_ON  = 12'hF40;

  localparam int SEL_IDX_W = 8;

  // Strobes from register control to the datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 rdHit;
    logic [SEL_IDX_W-1:0] idx;
  } cfgStrobe_t;

  function automatic logic maskCodeOk(input logic [MASK_W-1:0] code, input bit allowFull);
    case (code)
      4'h8, 4'hC, 4'hE, 4'hF: return 1'b1;
      4'h0:                   return allowFull;
      default:                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cs_win_ctrl.sv
`timescale 1ns/1ps
module cs_win_ctrl
  import cs_win_pkg::*;
#(
  parameter int NUM_CS       = 8,
  parameter int REG_AW       = 12,
  parameter int GROUP_BASE   = 32'h60,
  parameter int GROUP_STRIDE = 32'h30,
  parameter int WIN_OFS      = 32'h18
) (
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output cfgStrobe_t        strb
);

  // Address decode of the per-select window word
  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (regAddr == REG_AW'(GROUP_BASE + i * GROUP_STRIDE + WIN_OFS)) begin
        strb.rdHit = 1'b1;
        strb.idx   = SEL_IDX_W'(i);
      end
    end
    strb.wrEn = regWe & strb.rdHit;
  end

endmodule

// File: rtl/cs_win_match.sv
`timescale 1ns/1ps
module cs_win_match
  import cs_win_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_SHIFT  = 24,
  parameter bit ALLOW_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic              hit,
  output logic [ADDR_W-1:0] offset,
  output logic              badMask
);

  localparam int TOP_W = ADDR_W - WIN_SHIFT;

  logic [BASE_W-1:0] baseFld;
  logic [MASK_W-1:0] maskFld;
  logic              validFld;
  logic [TOP_W-1:0]  careTop;
  logic [TOP_W-1:0]  baseTop;
  logic [TOP_W-1:0]  addrTop;

  assign baseFld  = cfgWord[BASE_W-1:0];
  assign validFld = cfgWord[VALID_BIT];
  assign maskFld  = cfgWord[MASK_LSB +: MASK_W];

  // Bits of the top byte that take part in the compare
  assign careTop = {{(TOP_W - MASK_W){1'b1}}, maskFld};
  assign baseTop = {{(TOP_W - BASE_W){1'b0}}, baseFld};
  assign addrTop = accAddr[ADDR_W-1:WIN_SHIFT];

  assign hit     = accValid & validFld & (((addrTop ^ baseTop) & careTop) == '0);
  assign offset  = {addrTop & ~careTop, accAddr[WIN_SHIFT-1:0]};
  assign badMask = ~maskCodeOk(maskFld, ALLOW_FULL);

  // R2: the stored reserved bit never reaches the matcher as one
  a_r2_rsvd_clear: assert property (@(posedge clk) disable iff (!rstN)
    cfgWord[RSVD_BIT] == 1'b0);

  // R4: a claimed address shares the base under the cared bits
  a_r4_hit_in_window: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((accAddr[ADDR_W-1:WIN_SHIFT] & careTop) == (baseTop & careTop)));

endmodule

// File: rtl/cs_win_datapath.sv
`timescale 1ns/1ps
module cs_win_datapath
  import cs_win_pkg::*;
#(
  parameter int NUM_CS     = 8,
  parameter int ADDR_W     = 32,
  parameter int REG_DW     = 32,
  parameter int WIN_SHIFT  = 24,
  parameter bit ALLOW_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [NUM_CS-1:0] csSel,
  output logic [ADDR_W-1:0] csOffset,
  output logic              miss,
  output logic              overlap,
  output logic [NUM_CS-1:0] badMask
);

  localparam logic [REG_DW-1:0] KEEP_W = REG_DW'(CFG_KEEP);
  localparam logic [REG_DW-1:0] RST_ON = REG_DW'(CFG_RST_ON);
  localparam logic [REG_DW-1:0] RST_OFF = REG_DW'(CFG_RST_OFF);

  logic [REG_DW-1:0] cfgWord [NUM_CS];
  logic [NUM_CS-1:0] hitVec;
  logic [ADDR_W-1:0] offVec  [NUM_CS];

  // Window word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CS; i++) begin
        cfgWord[i] <= (i == 0) ? RST_ON : RST_OFF;
      end
    end else if (strb.wrEn) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (strb.idx == SEL_IDX_W'(i)) begin
          cfgWord[i] <= regWdata & KEEP_W;
        end
      end
    end
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (strb.rdHit && strb.idx == SEL_IDX_W'(i)) begin
        regRdata = cfgWord[i];
      end
    end
  end

  // One comparator per select
  for (genvar g = 0; g < NUM_CS; g++) begin : gMatch
    cs_win_match #(
      .ADDR_W     (ADDR_W),
      .WIN_SHIFT  (WIN_SHIFT),
      .ALLOW_FULL (ALLOW_FULL)
    ) u_match (
      .clk      (clk),
      .rstN     (rstN),
      .accValid (accValid),
      .accAddr  (accAddr),
      .cfgWord  (cfgWord[g][CFG_W-1:0]),
      .hit      (hitVec[g]),
      .offset   (offVec[g]),
      .badMask  (badMask[g])
    );

    // R5: a disabled select is never driven
    a_r5_enable_needed: assert property (@(posedge clk) disable iff (!rstN)
      csSel[g] |-> cfgWord[g][VALID_BIT]);

    // R2: a write to this select is stored, masked, at the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrEn && strb.idx == SEL_IDX_W'(g)) |=> (cfgWord[g] == ($past(regWdata) & KEEP_W)));
  end

  // Lowest-numbered claimant wins
  always_comb begin
    logic found;
    found    = 1'b0;
    csSel    = '0;
    csOffset = '0;
    overlap  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hitVec[i]) begin
        if (!found) begin
          found    = 1'b1;
          csSel[i] = 1'b1;
          csOffset = offVec[i];
        end else begin
          overlap = 1'b1;
        end
      end
    end
    miss = accValid & ~found;
  end

  a_r6_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSel));

  a_r6_overlap_has_winner: assert property (@(posedge clk) disable iff (!rstN)
    overlap |-> (csSel != '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (csSel == '0 && !miss && !overlap && csOffset == '0));

  a_r8_miss_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (miss != (|csSel)));

endmodule

// File: rtl/cs_window_decoder.sv
`timescale 1ns/1ps
module cs_window_decoder
  import cs_win_pkg::*;
#(
  parameter int NUM_CS       = 8,
  parameter int ADDR_W       = 32,
  parameter int REG_AW       = 12,
  parameter int REG_DW       = 32,
  parameter int WIN_SHIFT    = 24,
  parameter bit ALLOW_FULL   = 1'b0,
  parameter int GROUP_BASE   = 32'h60,
  parameter int GROUP_STRIDE = 32'h30,
  parameter int WIN_OFS      = 32'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [NUM_CS-1:0] csSel,
  output logic [ADDR_W-1:0] csOffset,
  output logic              miss,
  output logic              overlap,
  output logic [NUM_CS-1:0] badMask
);

  cfgStrobe_t strb;

  cs_win_ctrl #(
    .NUM_CS       (NUM_CS),
    .REG_AW       (REG_AW),
    .GROUP_BASE   (GROUP_BASE),
    .GROUP_STRIDE (GROUP_STRIDE),
    .WIN_OFS      (WIN_OFS)
  ) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  cs_win_datapath #(
    .NUM_CS     (NUM_CS),
    .ADDR_W     (ADDR_W),
    .REG_DW     (REG_DW),
    .WIN_SHIFT  (WIN_SHIFT),
    .ALLOW_FULL (ALLOW_FULL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .accValid (accValid),
    .accAddr  (accAddr),
    .csSel    (csSel),
    .csOffset (csOffset),
    .miss     (miss),
    .overlap  (overlap),
    .badMask  (badMask)
  );

endmodule

// File: tb/cs_window_decoder_tb.sv
`timescale 1ns/1ps
module cs_window_decoder_tb;

  localparam bit ALLOW_FULL_TB = 1'b0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [7:0]  csSel;
  logic [31:0] csOffset;
  logic        miss;
  logic        overlap;
  logic [7:0]  badMask;

  cs_window_decoder #(.ALLOW_FULL(ALLOW_FULL_TB)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .accValid(accValid),
    .accAddr(accAddr), .csSel(csSel), .csOffset(csOffset), .miss(miss),
    .overlap(overlap), .badMask(badMask)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [11:0] mw [8];

  function automatic logic [11:0] winAddr(int i);
    return 12'(32'h60 + i * 32'h30 + 32'h18);
  endfunction

  function automatic logic legalCode(logic [3:0] c);
    return (c == 4'h8 || c == 4'hC || c == 4'hE || c == 4'hF || (c == 4'h0 && ALLOW_FULL_TB));
  endfunction

  // Arithmetic model of R4..R8
  function automatic void model(input logic [31:0] a, output logic [7:0] sel,
                                output logic [31:0] off, output logic ms, output logic ov);
    int n = 0;
    sel = '0; off = '0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] sizeM1;
      logic [31:0] lo;
      sizeM1 = 32'h0FFFFFFF & ~({28'd0, mw[i][11:8]} << 24);
      lo = {2'b00, mw[i][5:0], 24'd0};
      if (mw[i][6] && (((a ^ lo) & ~sizeM1) == 32'd0)) begin
        n++;
        if (n == 1) begin
          sel = 8'(1 << i);
          off = a & sizeM1;
        end
      end
    end
    ms = (n == 0);
    ov = (n > 1);
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    for (int i = 0; i < 8; i++) if (a == winAddr(i)) mw[i] = d[11:0] & 12'hF7F;
  endtask

  task automatic checkRead(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    note(regRdata == exp, req, "read", {32'd0, regRdata}, {32'd0, exp});
  endtask

  task automatic checkNow(input logic [31:0] a, input string req);
    logic [7:0] es; logic [31:0] eo; logic em, ev;
    model(a, es, eo, em, ev);
    note(csSel == es && csOffset == eo && miss == em && overlap == ev, req, "decode",
         {22'd0, overlap, miss, csSel, csOffset}, {22'd0, ev, em, es, eo});
  endtask

  task automatic checkDecode(input logic [31:0] a, input string req);
    @(negedge clk);
    accValid = 1'b1; accAddr = a;
    #1;
    checkNow(a, req);
  endtask

  task automatic checkIdle(input logic [31:0] a);
    @(negedge clk);
    accValid = 1'b0; accAddr = a;
    #1;
    note(csSel == '0 && csOffset == '0 && !miss && !overlap, "R8", "idle",
         {22'd0, overlap, miss, csSel, csOffset}, 64'd0);
  endtask

  task automatic checkBad(input string req);
    logic [7:0] eb;
    for (int i = 0; i < 8; i++) eb[i] = ~legalCode(mw[i][11:8]);
    #1;
    note(badMask == eb, req, "badMask", {56'd0, badMask}, {56'd0, eb});
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 256; k++) begin
      checkDecode({k[7:0], 24'h000000}, req);
      checkDecode({k[7:0], 24'hFFFFFF}, req);
      checkDecode({k[7:0], 24'((k * 32'h00010307 + 32'h00A5C3))}, req);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    mw[0] = 12'hF40;
    for (int i = 1; i < 8; i++) mw[i] = 12'hF00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and flags
    for (int i = 0; i < 8; i++) checkRead(winAddr(i), (i == 0) ? 32'hF40 : 32'hF00, "R1");
    checkBad("R1");
    checkIdle(32'h00000000);

    // R3 R4 R7 R10: reset layout sweep
    sweep("R4");

    // R2: masking and ignored addresses
    doWrite(winAddr(7), 32'hFFFFFFBF);
    checkRead(winAddr(7), 32'h00000F3F, "R2");
    doWrite(12'h074, 32'hFFFFFFFF);
    doWrite(12'h079, 32'hFFFFFFFF);
    doWrite(12'h07C, 32'hFFFFFFFF);
    checkRead(winAddr(0), 32'h00000F40, "R2");
    checkRead(12'h074, 32'h0, "R2");
    checkRead(winAddr(1), 32'h00000F00, "R2");

    // Layout with all sizes, a disabled and an overlapping window
    doWrite(winAddr(0), 32'h00000840);  // 128 MB at 0x00
    doWrite(winAddr(1), 32'h00000C48);  // 64 MB at 0x08
    doWrite(winAddr(2), 32'h00000E4C);  // 32 MB at 0x0C
    doWrite(winAddr(3), 32'h00000F4E);  // 16 MB at 0x0E
    doWrite(winAddr(4), 32'h00000050);  // 256 MB at 0x10
    doWrite(winAddr(5), 32'h00000F22);  // disabled at 0x22
    doWrite(winAddr(6), 32'h00000F45);  // overlaps select 0
    for (int i = 0; i < 8; i++) checkRead(winAddr(i), {20'd0, mw[i]}, "R2");
    checkBad("R9");
    sweep("R5");
    checkDecode(32'h05123456, "R6");
    checkDecode(32'h0FFFFFFF, "R7");
    checkDecode(32'h22000000, "R5");

    // R8: strobe low
    checkIdle(32'h05123456);
    checkIdle(32'h10000000);

    // R9: every mask code on a disabled select
    for (int c = 0; c < 16; c++) begin
      doWrite(winAddr(5), 32'h00000022 | (32'(c) << 8));
      checkBad("R9");
    end

    // R2 R10: write and decode in the same cycle
    @(negedge clk);
    regWe = 1'b1; regAddr = winAddr(3); regWdata = 32'h00000F70;
    accValid = 1'b1; accAddr = 32'h0E001234;
    #1;
    checkNow(32'h0E001234, "R10");
    @(posedge clk);
    #1;
    mw[3] = 12'hF70;
    checkNow(32'h0E001234, "R2");
    @(negedge clk);
    regWe = 1'b0;
    checkDecode(32'h30000010, "R2");

    finishRun();
  end

endmodule